// File: doc/BRIEF.md
# Reducible-State Coherence Directory

This block is the directory controller for a small set of tracked lines shared by several private caches. The protocol is MSI with one more state, U. In U, any number of caches hold write permission to the same line under a common 3-bit label. Updates made under one label commute with each other, so holders apply them locally, with no coherence traffic. For each line the directory keeps a state, a holder bit vector (in M the vector names the one owner) and a label. It decides which caches must give up, downgrade or ship their copies when a request arrives.

Requests arrive one at a time on a valid/ready channel. The kinds are: read, write, labeled update (with a label), gather (pull partial copies from the other holders) and eviction notice. The answer can be a command token and a grant token, in that order, each on its own valid/ready channel. A command token carries a target bit vector, the cache that the copies travel to, and a count. The grant tells the requester its new permission, whether the directory sends data, and how many partial copies it must merge. When data has to travel between caches the line is marked busy. A separate completion strobe from the requester clears the busy mark. Data payloads, transport and the merge arithmetic are outside this block.

Top module: `redux_dir`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, reqReady is high and neither cmdValid nor grantValid is high.
- R2: A read (reqKind 0), write (1) or labeled update (2) to a line no cache holds is granted with data and with no command. The grant permission is S (grantPerm 1), M (2) or U (3). A U grant carries the request's label.
- R3: A write or labeled update to a line in S sends one invalidate command (cmdKind 1) to every other sharer. The requester is then granted M or U with data.
- R4: A labeled update whose label differs from the label of the current U holders sends a forward command (cmdKind 2) to every holder except the requester, naming the requester as cmdDest. The requester is granted U without data, with grantFwdCount equal to the number of forwarding caches and with the new label. It becomes the only holder.
- R5: A labeled update with the same label as the current U holders is granted U without data, with a forward count of 0 and no command. The requester joins the holders.
- R6: A read or write to a line in U sends a forward command to the other holders and grants M without data. The forward count equals the number of those holders. If the requester is the only holder, no command is sent and the forward count is 0. A write to a line owned in M by another cache forwards from that owner and grants M without data with a forward count of 1. A read of such a line sends a downgrade-to-S command (cmdKind 3) and grants S without data with a forward count of 1.
- R7: A labeled update to a line owned in M by another cache sends a downgrade-to-U command (cmdKind 4) to the owner. The requester is granted U without data, and both caches become holders under the new label.
- R8: When the last U holder evicts, the directory sends a writeback acknowledge (cmdKind 7) to that cache and the line becomes free. When other holders remain, one merge command (cmdKind 6) goes to exactly one of them, chosen pseudo-randomly and never the evicting cache, with cmdDest naming the evicting cache.
- R9: A gather (reqKind 3) from a U holder sends a gather command (cmdKind 5) to all other holders. cmdCount gives the total number of holders. No grant follows.
- R10: A gather to a line not in U, or an eviction notice (reqKind 4) from a cache that does not hold the line, produces no command and no grant, and leaves the holder set unchanged.
- R11: After a forward or downgrade-to-S command, the line is busy. A request to that line is not accepted (reqReady low) until doneValid is pulsed with that line in doneLine.
- R12: The command token, when there is one, is presented before the grant token and never at the same time. Each token is held with stable fields while its ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle if reqValid is high |
| reqKind | input | 3 | 0 read, 1 write, 2 labeled update, 3 gather, 4 eviction notice |
| reqCache | input | CW | Requesting cache index |
| reqLine | input | LW | Tracked line index |
| reqLabel | input | 3 | Label of a labeled update |
| doneValid | input | 1 | Completion strobe that clears the busy mark |
| doneLine | input | LW | Line whose busy mark is cleared |
| cmdValid | output | 1 | Command token present |
| cmdReady | input | 1 | Command token taken |
| cmdKind | output | 3 | 1 invalidate, 2 forward, 3 downgrade S, 4 downgrade U, 5 gather, 6 merge, 7 writeback acknowledge |
| cmdTarget | output | N | Caches that receive the command |
| cmdDest | output | CW | Cache that copies travel to (the requester) |
| cmdLine | output | LW | Line of the command |
| cmdCount | output | CW+1 | Holder or forwarder count carried by the command |
| grantValid | output | 1 | Grant token present |
| grantReady | input | 1 | Grant token taken |
| grantCache | output | CW | Cache receiving the grant |
| grantLine | output | LW | Line of the grant |
| grantPerm | output | 2 | 1 S, 2 M, 3 U |
| grantWithData | output | 1 | Directory sends the line data |
| grantFwdCount | output | CW+1 | Partial copies the requester must merge |
| grantLabel | output | 3 | Label of a U grant, otherwise 0 |

## Verification
The checker relies on the caches keeping to the handshake rules. Once a token is presented, its ready input is the only thing the environment changes. doneValid names only a line that is busy. An eviction comes only from a cache the requester side believes is a holder, or it is deliberately stray. The stimulus is issued one request at a time, each driven on the falling edge and held until accepted. A completion strobe follows every operation that moves copies between caches. The ready inputs are lowered only around a token that is already presented.

// File: rtl/redux_dir_pkg.sv
package redux_dir_pkg;
  parameter int NCACHE = 4;
  parameter int NLINE = 4;
  parameter int LABELW = 3;
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1;
  localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1;
  localparam int CNTW = CW + 1;

  typedef enum logic [2:0] {
    RQ_GETS = 3'd0, RQ_GETX = 3'd1, RQ_GETU = 3'd2, RQ_GATHER = 3'd3, RQ_EVICT = 3'd4
  } reqKind_e;

  typedef enum logic [1:0] {
    LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2, LS_U = 2'd3
  } lineState_e;

  typedef enum logic [2:0] {
    CK_NONE = 3'd0, CK_INV = 3'd1, CK_FWD = 3'd2, CK_DOWNS = 3'd3,
    CK_DOWNU = 3'd4, CK_GATHER = 3'd5, CK_MERGE = 3'd6, CK_WBACK = 3'd7
  } cmdKind_e;

  // Update strobes from control to the line table
  typedef struct packed {
    logic wr;
    logic [LW-1:0] line;
    lineState_e st;
    logic [NCACHE-1:0] sh;
    logic [LABELW-1:0] lb;
    logic setBusy;
  } tblStrobe_t;

  function automatic logic [CNTW-1:0] popc(input logic [NCACHE-1:0] v);
    logic [CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < NCACHE; i++) n = n + CNTW'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/redux_dir_picker.sv
module redux_dir_picker
  import redux_dir_pkg::*;
(
  input  logic [NCACHE-1:0] mask,
  input  logic [CW-1:0] start,
  output logic [NCACHE-1:0] pick
);
  // Rotated scan: first set bit at or after the start position, wrapping
  always_comb begin
    logic found;
    pick = '0;
    found = 1'b0;
    for (int i = 0; i < NCACHE; i++) begin
      int idx;
      idx = (int'(start) + i) % NCACHE;
      if (!found && mask[idx]) begin
        pick[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/redux_dir_table.sv
module redux_dir_table
  import redux_dir_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [LW-1:0] rdLine,
  input  tblStrobe_t strobe,
  input  logic doneValid,
  input  logic [LW-1:0] doneLine,
  input  logic [NCACHE-1:0] pickMask,
  output lineState_e rdState,
  output logic [NCACHE-1:0] rdSharers,
  output logic [LABELW-1:0] rdLabel,
  output logic rdBusy,
  output logic [NCACHE-1:0] pickOut
);
  localparam int LFSRW = 8;

  lineState_e stArr [NLINE];
  logic [NCACHE-1:0] shArr [NLINE];
  logic [LABELW-1:0] lbArr [NLINE];
  logic [NLINE-1:0] busyVec;
  logic [NLINE-1:0] wrHit, doneHit;
  logic [LFSRW-1:0] lfsr;

  for (genvar g = 0; g < NLINE; g++) begin : gHit
    assign wrHit[g] = strobe.wr && (strobe.line == LW'(g));
    assign doneHit[g] = doneValid && (doneLine == LW'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLINE; i++) begin
        stArr[i] <= LS_I;
        shArr[i] <= '0;
        lbArr[i] <= '0;
      end
      busyVec <= '0;
    end else begin
      for (int i = 0; i < NLINE; i++) begin
        if (wrHit[i]) begin
          stArr[i] <= strobe.st;
          shArr[i] <= strobe.sh;
          lbArr[i] <= strobe.lb;
        end
        if (doneHit[i]) busyVec[i] <= 1'b0;
        if (strobe.setBusy && strobe.line == LW'(i)) busyVec[i] <= 1'b1;
      end
    end
  end

  // Free-running pseudo-random source for the merge-target choice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= 8'h5A;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  assign rdState = stArr[rdLine];
  assign rdSharers = shArr[rdLine];
  assign rdLabel = lbArr[rdLine];
  assign rdBusy = busyVec[rdLine];

  redux_dir_picker uPick (
    .mask(pickMask),
    .start(lfsr[CW-1:0]),
    .pick(pickOut)
  );
endmodule

// File: rtl/redux_dir_ctrl.sv
module redux_dir_ctrl
  import redux_dir_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  logic [2:0] reqKind,
  input  logic [CW-1:0] reqCache,
  input  logic [LW-1:0] reqLine,
  input  logic [LABELW-1:0] reqLabel,
  input  lineState_e rdState,
  input  logic [NCACHE-1:0] rdSharers,
  input  logic [LABELW-1:0] rdLabel,
  input  logic rdBusy,
  input  logic [NCACHE-1:0] pickOut,
  output logic [NCACHE-1:0] pickMask,
  output tblStrobe_t strobe,
  output logic cmdValid,
  input  logic cmdReady,
  output logic [2:0] cmdKind,
  output logic [NCACHE-1:0] cmdTarget,
  output logic [CW-1:0] cmdDest,
  output logic [LW-1:0] cmdLine,
  output logic [CNTW-1:0] cmdCount,
  output logic grantValid,
  input  logic grantReady,
  output logic [CW-1:0] grantCache,
  output logic [LW-1:0] grantLine,
  output logic [1:0] grantPerm,
  output logic grantWithData,
  output logic [CNTW-1:0] grantFwdCount,
  output logic [LABELW-1:0] grantLabel
);
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_GRANT} phase_e;
  phase_e phase;

  logic fire;
  logic [NCACHE-1:0] reqBit, others;
  logic isHolder, hasOthers;

  cmdKind_e dCmd;
  logic [NCACHE-1:0] dTarget;
  logic [CNTW-1:0] dCount, dFwd;
  logic dGrant, dData, dWr, dBusy;
  lineState_e dPerm, nSt;
  logic [NCACHE-1:0] nSh;
  logic [LABELW-1:0] nLb, dLabel;

  assign reqReady = (phase == ST_IDLE) && !rdBusy;
  assign fire = reqValid && reqReady;
  assign reqBit = {{(NCACHE-1){1'b0}}, 1'b1} << reqCache;
  assign others = rdSharers & ~reqBit;
  assign isHolder = |(rdSharers & reqBit);
  assign hasOthers = |others;
  assign pickMask = others;

  always_comb begin
    dCmd = CK_NONE;
    dTarget = '0;
    dCount = '0;
    dGrant = 1'b0;
    dPerm = LS_I;
    dData = 1'b0;
    dFwd = '0;
    dLabel = '0;
    dWr = 1'b0;
    dBusy = 1'b0;
    nSt = rdState;
    nSh = rdSharers;
    nLb = rdLabel;
    unique case (reqKind)
      RQ_GETS, RQ_GETX: begin
        dGrant = 1'b1;
        dWr = 1'b1;
        unique case (rdState)
          LS_I: begin
            nSt = (reqKind == RQ_GETS) ? LS_S : LS_M;
            nSh = reqBit;
            dPerm = nSt;
            dData = 1'b1;
          end
          LS_S: begin
            dData = 1'b1;
            if (reqKind == RQ_GETS) begin
              nSh = rdSharers | reqBit;
              dPerm = LS_S;
            end else begin
              nSt = LS_M;
              nSh = reqBit;
              dPerm = LS_M;
              if (hasOthers) begin
                dCmd = CK_INV;
                dTarget = others;
              end
            end
          end
          LS_M: begin
            if (!hasOthers) begin
              dPerm = LS_M;
            end else if (reqKind == RQ_GETS) begin
              dCmd = CK_DOWNS;
              dTarget = others;
              dCount = CNTW'(1);
              dBusy = 1'b1;
              nSt = LS_S;
              nSh = others | reqBit;
              dPerm = LS_S;
              dFwd = CNTW'(1);
            end else begin
              dCmd = CK_FWD;
              dTarget = others;
              dCount = CNTW'(1);
              dBusy = 1'b1;
              nSh = reqBit;
              dPerm = LS_M;
              dFwd = CNTW'(1);
            end
          end
          default: begin
            // Reduction of all partial copies into a single M owner
            nSt = LS_M;
            nSh = reqBit;
            dPerm = LS_M;
            dFwd = popc(others);
            if (hasOthers) begin
              dCmd = CK_FWD;
              dTarget = others;
              dCount = popc(others);
              dBusy = 1'b1;
            end
          end
        endcase
      end
      RQ_GETU: begin
        dGrant = 1'b1;
        dWr = 1'b1;
        dPerm = LS_U;
        dLabel = reqLabel;
        nSt = LS_U;
        nLb = reqLabel;
        unique case (rdState)
          LS_I: begin
            nSh = reqBit;
            dData = 1'b1;
          end
          LS_S: begin
            nSh = reqBit;
            dData = 1'b1;
            if (hasOthers) begin
              dCmd = CK_INV;
              dTarget = others;
            end
          end
          LS_M: begin
            nSh = others | reqBit;
            if (hasOthers) begin
              dCmd = CK_DOWNU;
              dTarget = others;
              dCount = CNTW'(1);
            end
          end
          default: begin
            if (rdLabel == reqLabel) begin
              nSh = rdSharers | reqBit;
            end else begin
              nSh = reqBit;
              dFwd = popc(others);
              if (hasOthers) begin
                dCmd = CK_FWD;
                dTarget = others;
                dCount = popc(others);
                dBusy = 1'b1;
              end
            end
          end
        endcase
      end
      RQ_GATHER: begin
        if (rdState == LS_U && isHolder && hasOthers) begin
          dCmd = CK_GATHER;
          dTarget = others;
          dCount = popc(rdSharers);
        end
      end
      RQ_EVICT: begin
        if (isHolder) begin
          dWr = 1'b1;
          if (rdState == LS_U && hasOthers) begin
            nSh = others;
            dCmd = CK_MERGE;
            dTarget = pickOut;
            dCount = CNTW'(1);
          end else if (rdState == LS_S) begin
            nSh = others;
            nSt = hasOthers ? LS_S : LS_I;
          end else begin
            nSt = LS_I;
            nSh = '0;
            dCmd = CK_WBACK;
            dTarget = reqBit;
          end
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    strobe.wr = fire && dWr;
    strobe.line = reqLine;
    strobe.st = nSt;
    strobe.sh = nSh;
    strobe.lb = nLb;
    strobe.setBusy = fire && dBusy;
  end

  logic grantPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      grantPend <= 1'b0;
      cmdKind <= '0;
      cmdTarget <= '0;
      cmdDest <= '0;
      cmdLine <= '0;
      cmdCount <= '0;
      grantCache <= '0;
      grantLine <= '0;
      grantPerm <= '0;
      grantWithData <= 1'b0;
      grantFwdCount <= '0;
      grantLabel <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (fire) begin
          cmdKind <= dCmd;
          cmdTarget <= dTarget;
          cmdDest <= reqCache;
          cmdLine <= reqLine;
          cmdCount <= dCount;
          grantPend <= dGrant;
          grantCache <= reqCache;
          grantLine <= reqLine;
          grantPerm <= dPerm;
          grantWithData <= dData;
          grantFwdCount <= dFwd;
          grantLabel <= dLabel;
          if (dCmd != CK_NONE) phase <= ST_CMD;
          else if (dGrant) phase <= ST_GRANT;
        end
        ST_CMD: if (cmdReady) phase <= grantPend ? ST_GRANT : ST_IDLE;
        default: if (grantReady) phase <= ST_IDLE;
      endcase
    end
  end

  assign cmdValid = (phase == ST_CMD);
  assign grantValid = (phase == ST_GRANT);
endmodule

// File: rtl/redux_dir.sv
module redux_dir
  import redux_dir_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  logic [2:0] reqKind,
  input  logic [CW-1:0] reqCache,
  input  logic [LW-1:0] reqLine,
  input  logic [LABELW-1:0] reqLabel,
  input  logic doneValid,
  input  logic [LW-1:0] doneLine,
  output logic cmdValid,
  input  logic cmdReady,
  output logic [2:0] cmdKind,
  output logic [NCACHE-1:0] cmdTarget,
  output logic [CW-1:0] cmdDest,
  output logic [LW-1:0] cmdLine,
  output logic [CNTW-1:0] cmdCount,
  output logic grantValid,
  input  logic grantReady,
  output logic [CW-1:0] grantCache,
  output logic [LW-1:0] grantLine,
  output logic [1:0] grantPerm,
  output logic grantWithData,
  output logic [CNTW-1:0] grantFwdCount,
  output logic [LABELW-1:0] grantLabel
);
  tblStrobe_t strobe;
  lineState_e rdState;
  logic [NCACHE-1:0] rdSharers, pickMask, pickOut;
  logic [LABELW-1:0] rdLabel;
  logic rdBusy;

  redux_dir_table uTable (
    .clk(clk), .rstN(rstN), .rdLine(reqLine), .strobe(strobe),
    .doneValid(doneValid), .doneLine(doneLine), .pickMask(pickMask),
    .rdState(rdState), .rdSharers(rdSharers), .rdLabel(rdLabel),
    .rdBusy(rdBusy), .pickOut(pickOut)
  );

  redux_dir_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqCache(reqCache), .reqLine(reqLine), .reqLabel(reqLabel),
    .rdState(rdState), .rdSharers(rdSharers), .rdLabel(rdLabel), .rdBusy(rdBusy),
    .pickOut(pickOut), .pickMask(pickMask), .strobe(strobe),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
    .cmdTarget(cmdTarget), .cmdDest(cmdDest), .cmdLine(cmdLine), .cmdCount(cmdCount),
    .grantValid(grantValid), .grantReady(grantReady), .grantCache(grantCache),
    .grantLine(grantLine), .grantPerm(grantPerm), .grantWithData(grantWithData),
    .grantFwdCount(grantFwdCount), .grantLabel(grantLabel)
  );
endmodule

// File: rtl/redux_dir_chk.sv
module redux_dir_chk
  import redux_dir_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic cmdValid,
  input logic cmdReady,
  input logic [2:0] cmdKind,
  input logic [NCACHE-1:0] cmdTarget,
  input logic [CW-1:0] cmdDest,
  input logic grantValid,
  input logic grantReady,
  input logic [1:0] grantPerm,
  input logic grantWithData,
  input logic [CNTW-1:0] grantFwdCount,
  input logic [CW-1:0] grantCache
);
  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdKind) && $stable(cmdTarget) && $stable(cmdDest));

  // R12
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !grantReady |=> grantValid && $stable(grantPerm) && $stable(grantCache)
      && $stable(grantFwdCount));

  // R12
  token_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && grantValid));

  // R8
  merge_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKind == 3'd6 |-> $onehot(cmdTarget) && !cmdTarget[cmdDest]);

  // R4
  fwd_not_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKind inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5} |-> cmdTarget != '0 && !cmdTarget[cmdDest]);

  // R2
  data_no_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && grantWithData |-> grantFwdCount == '0);

  // R1
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |-> !cmdValid && !grantValid);
endmodule

bind redux_dir redux_dir_chk uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind), .cmdTarget(cmdTarget),
  .cmdDest(cmdDest), .grantValid(grantValid), .grantReady(grantReady),
  .grantPerm(grantPerm), .grantWithData(grantWithData), .grantFwdCount(grantFwdCount),
  .grantCache(grantCache)
);

// File: tb/tb_redux_dir.sv
module tb_redux_dir;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, reqValid, reqReady, doneValid, cmdValid, cmdReady, grantValid, grantReady;
  logic [2:0] reqKind, reqLabel, cmdKind, grantLabel;
  logic [1:0] reqCache, reqLine, doneLine, cmdDest, cmdLine, grantCache, grantLine, grantPerm;
  logic [3:0] cmdTarget;
  logic [2:0] cmdCount, grantFwdCount;
  logic grantWithData;

  redux_dir dut (.*);

  int nChk = 0, nFail = 0;
  logic gotCmd, gotGrant;
  logic [2:0] cK, cC, gF, gL;
  logic [3:0] cT;
  logic [1:0] cD, gP, gC;
  logic gD;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic observe();
    gotCmd = 1'b0;
    gotGrant = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (cmdValid && !gotCmd) begin
        gotCmd = 1'b1; cK = cmdKind; cT = cmdTarget; cD = cmdDest; cC = cmdCount;
      end
      if (grantValid && !gotGrant) begin
        gotGrant = 1'b1; gP = grantPerm; gD = grantWithData; gF = grantFwdCount;
        gL = grantLabel; gC = grantCache;
      end
      @(negedge clk);
    end
  endtask

  task automatic send(input int kind, input int cache, input int line, input int label);
    reqValid = 1'b1; reqKind = 3'(kind); reqCache = 2'(cache);
    reqLine = 2'(line); reqLabel = 3'(label);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    observe();
  endtask

  task automatic done(input int line);
    doneValid = 1'b1; doneLine = 2'(line);
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic expCmd(input string tag, input int k, input int t, input int d, input int c);
    chk({tag, " cmd present"}, 32'(gotCmd), 1);
    chk({tag, " cmdKind"}, 32'(cK), 32'(k));
    chk({tag, " cmdTarget"}, 32'(cT), 32'(t));
    chk({tag, " cmdDest"}, 32'(cD), 32'(d));
    chk({tag, " cmdCount"}, 32'(cC), 32'(c));
  endtask

  task automatic expGrant(input string tag, input int cache, input int perm, input int data,
                          input int fwd, input int label);
    chk({tag, " grant present"}, 32'(gotGrant), 1);
    chk({tag, " grantCache"}, 32'(gC), 32'(cache));
    chk({tag, " grantPerm"}, 32'(gP), 32'(perm));
    chk({tag, " grantWithData"}, 32'(gD), 32'(data));
    chk({tag, " grantFwdCount"}, 32'(gF), 32'(fwd));
    chk({tag, " grantLabel"}, 32'(gL), 32'(label));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqCache = '0; reqLine = '0; reqLabel = '0;
    doneValid = 1'b0; doneLine = '0; cmdReady = 1'b1; grantReady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reqReady in reset", 32'(reqReady), 1);
    chk("R1 cmdValid in reset", 32'(cmdValid), 0);
    chk("R1 grantValid in reset", 32'(grantValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqReady after reset", 32'(reqReady), 1);
    chk("R1 idle outputs after reset", 32'({cmdValid, grantValid}), 0);

    // Line 0: U holders under label 2
    send(2, 0, 0, 2);
    chk("R2 no cmd", 32'(gotCmd), 0);
    expGrant("R2 free line GETU", 0, 3, 1, 0, 2);
    send(2, 1, 0, 2);
    chk("R5 no cmd", 32'(gotCmd), 0);
    expGrant("R5 same label", 1, 3, 0, 0, 2);
    send(2, 2, 0, 2);
    expGrant("R5 same label third", 2, 3, 0, 0, 2);
    send(3, 1, 0, 0);
    expCmd("R9 gather", 5, 4'b0101, 1, 3);
    chk("R9 no grant", 32'(gotGrant), 0);
    send(2, 3, 0, 5);
    expCmd("R4 label change", 2, 4'b0111, 3, 3);
    expGrant("R4 label change", 3, 3, 0, 3, 5);

    // R11: line 0 is busy until the completion strobe
    reqValid = 1'b1; reqKind = 3'd0; reqCache = 2'd0; reqLine = 2'd0; reqLabel = '0;
    for (int k = 0; k < 3; k++) begin
      chk("R11 stalled while busy", 32'(reqReady), 0);
      @(negedge clk);
    end
    done(0);
    chk("R11 accepted after done", 32'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    observe();
    expCmd("R6 read of U line", 2, 4'b1000, 0, 1);
    expGrant("R6 read of U line", 0, 2, 0, 1, 0);
    done(0);

    send(2, 1, 0, 4);
    expCmd("R7 downgrade owner", 4, 4'b0001, 1, 1);
    expGrant("R7 downgrade owner", 1, 3, 0, 0, 4);
    send(4, 0, 0, 0);
    expCmd("R8 merge to remaining", 6, 4'b0010, 0, 1);
    chk("R8 no grant on evict", 32'(gotGrant), 0);
    send(4, 1, 0, 0);
    expCmd("R8 last holder writeback", 7, 4'b0010, 1, 0);
    send(0, 2, 0, 0);
    expGrant("R2 read after writeback", 2, 1, 1, 0, 0);
    send(0, 3, 0, 0);
    expGrant("R2 second reader", 3, 1, 1, 0, 0);
    send(2, 1, 0, 1);
    expCmd("R3 invalidate sharers", 1, 4'b1100, 1, 0);
    expGrant("R3 invalidate sharers", 1, 3, 1, 0, 1);

    // Line 1: pseudo-random merge target among {0,1,3}
    send(2, 0, 1, 3);
    send(2, 1, 1, 3);
    send(2, 3, 1, 3);
    for (int r = 0; r < 4; r++) begin
      send(2, 2, 1, 3);
      expGrant("R5 rejoin", 2, 3, 0, 0, 3);
      repeat (r) @(negedge clk);
      send(4, 2, 1, 0);
      chk("R8 merge kind", 32'(cK), 6);
      chk("R8 merge one target", 32'($onehot(cT)), 1);
      chk("R8 merge target is holder", 32'((cT & ~4'b1011) == 4'b0), 1);
      chk("R8 merge dest", 32'(cD), 2);
    end
    send(4, 2, 1, 0);
    chk("R10 stray evict no cmd", 32'(gotCmd), 0);
    chk("R10 stray evict no grant", 32'(gotGrant), 0);
    send(3, 0, 1, 0);
    expCmd("R10 holders unchanged", 5, 4'b1010, 0, 3);

    // Line 2: ignored gather, then ownership transfers
    send(3, 0, 2, 0);
    chk("R10 gather on free line no cmd", 32'(gotCmd), 0);
    chk("R10 gather on free line no grant", 32'(gotGrant), 0);
    send(1, 1, 2, 0);
    expGrant("R2 write free line", 1, 2, 1, 0, 0);
    cmdReady = 1'b0;
    send(1, 3, 2, 0);
    expCmd("R6 write to owned line", 2, 4'b0010, 3, 1);
    chk("R12 grant waits for cmd", 32'(gotGrant), 0);
    chk("R12 cmd held", 32'(cmdValid), 1);
    cmdReady = 1'b1;
    observe();
    expGrant("R6 write to owned line", 3, 2, 0, 1, 0);
    done(2);
    send(0, 0, 2, 0);
    expCmd("R6 read of owned line", 3, 4'b1000, 0, 1);
    expGrant("R6 read of owned line", 0, 1, 0, 1, 0);
    done(2);

    // Line 3: grant hold, then sole-holder reduction
    grantReady = 1'b0;
    send(0, 0, 3, 0);
    expGrant("R2 read free line", 0, 1, 1, 0, 0);
    chk("R12 grant held", 32'(grantValid), 1);
    chk("R12 grant perm stable", 32'(grantPerm), 1);
    chk("R12 no accept while granting", 32'(reqReady), 0);
    grantReady = 1'b1;
    @(negedge clk);
    chk("R12 grant released", 32'(grantValid), 0);
    send(2, 0, 3, 0);
    chk("R3 no other sharer no cmd", 32'(gotCmd), 0);
    expGrant("R3 sole sharer upgrade", 0, 3, 1, 0, 0);
    send(1, 0, 3, 0);
    chk("R6 sole holder no cmd", 32'(gotCmd), 0);
    expGrant("R6 sole holder", 0, 2, 0, 0, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule